// File: doc/BRIEF.md
# Round-Key Expander with Borrowed Substitution Port

This block turns a 128-bit or 256-bit cipher key into the complete list of round keys for the standard 128-bit block cipher. It keeps the keys in a register array that the encipher and decipher datapaths read by round number. It has no substitution boxes of its own. Each cycle that derives a new round key, it sends one 32-bit word out on a request port and takes the byte-wise substituted word back on a response port, all within the same cycle. In the full design, that port is the encipher datapath's bank of four forward S-boxes. The two users of those S-boxes cannot share them, so the block keeps its ready flag low for the whole expansion and raises a use strobe in every cycle that it occupies the port.

An expansion starts with a one-cycle init pulse. On that pulse the block samples the key bus and the length select. A 128-bit key sits in the upper half of the key bus. The first round key is always the upper half of the key bus. For a 256-bit key, the second round key is the lower half, and it is loaded in a cycle that does not use the substitution port. After that, the block derives one round key per cycle. A pulse on init while an expansion is running abandons that run and starts a new one.

Top module: `rkey_expand`

## Requirements
- R1: During and after reset, `ready_o` and `sbox_use_o` are 0 until an expansion completes.
- R2: With `len256_i`=0 at init, round keys 0..10 equal the standard 128-bit key schedule. Round key 0 is `key_i[255:128]`. Key word 0 of each round key sits in bits [127:96]. The round constant starts at 0x01 and is doubled in GF(2^8) with reduction by 0x1b each time it is used.
- R3: With `len256_i`=1 at init, round keys 0..14 equal the standard 256-bit key schedule. Round key 0 is `key_i[255:128]` and round key 1 is `key_i[127:0]`.
- R4: In a 256-bit run, an even-numbered round key uses rotation, substitution and the round constant on the last word of the previous key. An odd-numbered round key uses substitution only.
- R5: `key_i` and `len256_i` are sampled only in the init cycle. Changing them during an expansion has no effect on the stored keys or on the run length.
- R6: `ready_o` is 0 from the cycle after init until the last round key is written. It reads 1 exactly 10 clock edges after the init edge for 128-bit keys and 14 edges after for 256-bit keys.
- R7: `sbox_use_o` is 1 in exactly the cycles that derive a round key: 10 cycles for a 128-bit key and 13 for a 256-bit key. It is 0 in the load cycle of round key 1. In each of those cycles, `sbox_word_o` is the last word of the previous round key, rotated left by one byte on rotation steps.
- R8: An init pulse during an expansion restarts it. The stored keys and the ready timing then follow only the new key and length.
- R9: A read with `rd_idx_i` = 15 returns all zeros. Any other index returns the stored round key combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| init_i | input | 1 | Start expansion; samples key and length |
| key_i | input | 256 | Cipher key; 128-bit keys in the upper half |
| len256_i | input | 1 | 1 selects a 256-bit key, 0 a 128-bit key |
| rd_idx_i | input | 4 | Round-key read index |
| rd_key_o | output | 128 | Round key at `rd_idx_i` |
| ready_o | output | 1 | All round keys valid; block processing allowed |
| sbox_use_o | output | 1 | Substitution port is occupied this cycle |
| sbox_word_o | output | 32 | Word sent to the shared S-boxes |
| sbox_word_i | input | 32 | Substituted word returned by the shared S-boxes |

## Verification
Two functions can collide in one cycle: a new init pulse and the write of a derived round key that is still in flight. The bench sends a second init four cycles into a 128-bit run, with a 256-bit key. It then judges the outcome by three things: the 14-edge ready delay, the 13-cycle port occupancy with the expected request words, and all fifteen read-back keys matching the second key's schedule. In a separate run, the key and length inputs are flipped in the middle of the expansion, and the result must be unaffected.

// File: rtl/rkey_pkg.sv
package rkey_pkg;
  localparam int unsigned KEY_W  = 256;
  localparam int unsigned BLK_W  = 128;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned RK_N   = 15;
  localparam int unsigned IDX_W  = $clog2(RK_N + 1);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD1 = 2'd1,
    ST_RUN   = 2'd2
  } rk_state_e;
endpackage

// File: rtl/rkey_sbox4.sv
module rkey_sbox4 #(
  parameter int unsigned LANES = 4
) (
  input  logic [8*LANES-1:0] word_i,
  output logic [8*LANES-1:0] word_o
);
  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, x;
    p = '0;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = {x[6:0], 1'b0} ^ (x[7] ? 8'h1b : 8'h00);
    end
    return p;
  endfunction

  // x^254 as the product x^2 * x^4 * ... * x^128
  function automatic logic [7:0] sub_byte(input logic [7:0] a);
    logic [7:0] sq, inv;
    sq  = a;
    inv = 8'h01;
    for (int k = 1; k < 8; k++) begin
      sq  = gf_mul(sq, sq);
      inv = gf_mul(inv, sq);
    end
    return inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
               ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
  endfunction

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign word_o[8*g +: 8] = sub_byte(word_i[8*g +: 8]);
  end
endmodule

// File: rtl/rkey_rcon.sv
module rkey_rcon (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       adv_i,
  output logic [7:0] rcon_o
);
  logic [7:0] rcon_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rcon_q <= 8'h01;
    else if (clr_i) rcon_q <= 8'h01;
    else if (adv_i) rcon_q <= {rcon_q[6:0], 1'b0} ^ (rcon_q[7] ? 8'h1b : 8'h00);
  end

  assign rcon_o = rcon_q;

  // R2
  rcon_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !adv_i) |=> $stable(rcon_o));
  // R2
  rcon_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (rcon_o == 8'h01));
endmodule

// File: rtl/rkey_store.sv
module rkey_store #(
  parameter int unsigned DEPTH = 15,
  parameter int unsigned W     = 128,
  parameter int unsigned IW    = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [W-1:0]  wr_data_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [W-1:0]  rd_data_o
);
  logic [W-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 mem_q[g] <= '0;
      else if (wr_en_i && wr_idx_i == IW'(g))      mem_q[g] <= wr_data_i;
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < DEPTH; i++)
      if (rd_idx_i == IW'(i)) rd_data_o = mem_q[i];
  end

  // R9
  wr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> (int'(wr_idx_i) < DEPTH));
endmodule

// File: rtl/rkey_expand.sv
module rkey_expand
  import rkey_pkg::*;
#(
  parameter int unsigned KW  = KEY_W,
  parameter int unsigned BW  = BLK_W,
  parameter int unsigned WW  = WORD_W,
  parameter int unsigned NRK = RK_N,
  parameter int unsigned IW  = IDX_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          init_i,
  input  logic [KW-1:0] key_i,
  input  logic          len256_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [BW-1:0] rd_key_o,
  output logic          ready_o,
  output logic          sbox_use_o,
  output logic [WW-1:0] sbox_word_o,
  input  logic [WW-1:0] sbox_word_i
);
  localparam int unsigned NWORD   = BW / WW;
  localparam int unsigned LAST128 = 10;
  localparam int unsigned LAST256 = NRK - 1;

  rk_state_e     state_q;
  logic [BW-1:0] prev_q, prev2_q, new_key;
  logic [IW-1:0] idx_q, last_idx;
  logic          is256_q, ready_q;
  logic          rot_step, rc_adv;
  logic [WW-1:0] last_w, tfm_w;
  logic [7:0]    rcon;
  logic          wr_en;
  logic [IW-1:0] wr_idx;
  logic [BW-1:0] wr_data;

  assign last_idx   = is256_q ? IW'(LAST256) : IW'(LAST128);
  assign rot_step   = !is256_q || !idx_q[0];
  assign last_w     = prev_q[WW-1:0];
  assign sbox_use_o = (state_q == ST_RUN);
  assign sbox_word_o = rot_step ? {last_w[WW-9:0], last_w[WW-1:WW-8]} : last_w;
  assign tfm_w      = sbox_word_i ^ (rot_step ? {rcon, {(WW-8){1'b0}}} : '0);
  assign rc_adv     = sbox_use_o && rot_step && !init_i;

  always_comb begin
    logic [BW-1:0] base;
    logic [WW-1:0] acc;
    base = is256_q ? prev2_q : prev_q;
    acc  = tfm_w;
    for (int j = 0; j < NWORD; j++) begin
      acc = acc ^ base[BW-1-WW*j -: WW];
      new_key[BW-1-WW*j -: WW] = acc;
    end
  end

  always_comb begin
    wr_en   = 1'b0;
    wr_idx  = idx_q;
    wr_data = new_key;
    if (init_i) begin
      wr_en   = 1'b1;
      wr_idx  = '0;
      wr_data = key_i[KW-1 -: BW];
    end else if (state_q == ST_LOAD1) begin
      wr_en   = 1'b1;
      wr_data = prev2_q;
    end else if (state_q == ST_RUN) begin
      wr_en   = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      prev_q  <= '0;
      prev2_q <= '0;
      idx_q   <= '0;
      is256_q <= 1'b0;
      ready_q <= 1'b0;
    end else if (init_i) begin
      prev_q  <= key_i[KW-1 -: BW];
      prev2_q <= key_i[BW-1:0];
      is256_q <= len256_i;
      idx_q   <= IW'(1);
      ready_q <= 1'b0;
      state_q <= len256_i ? ST_LOAD1 : ST_RUN;
    end else begin
      case (state_q)
        ST_LOAD1: begin
          prev_q  <= prev2_q;
          prev2_q <= prev_q;
          idx_q   <= IW'(2);
          state_q <= ST_RUN;
        end
        ST_RUN: begin
          prev2_q <= prev_q;
          prev_q  <= new_key;
          if (idx_q == last_idx) begin
            state_q <= ST_IDLE;
            ready_q <= 1'b1;
          end else begin
            idx_q <= idx_q + IW'(1);
          end
        end
        default: ;
      endcase
    end
  end

  assign ready_o = ready_q;

  rkey_rcon u_rcon (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (init_i),
    .adv_i  (rc_adv),
    .rcon_o (rcon)
  );

  rkey_store #(.DEPTH(NRK), .W(BW), .IW(IW)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_data_i (wr_data),
    .rd_idx_i  (rd_idx_i),
    .rd_data_o (rd_key_o)
  );

  // R6
  ready_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sbox_use_o |-> !ready_o);
  // R6
  ready_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(sbox_use_o));
  // R8
  init_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> !ready_o);
  // R7
  load_no_sbox_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_i && len256_i) |=> !sbox_use_o);
endmodule

// File: tb/rkey_expand_bench.sv
module rkey_expand_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         init = 1'b0;
  logic [255:0] key = '0;
  logic         len256 = 1'b0;
  logic [3:0]   rd_idx = '0;
  logic [127:0] rd_key;
  logic         ready, sb_use;
  logic [31:0]  sb_req, sb_rsp;

  int chk_cnt = 0;
  int pass_cnt = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  rkey_expand u_rkey_expand (
    .clk_i(clk), .rst_ni(rst_n), .init_i(init), .key_i(key), .len256_i(len256),
    .rd_idx_i(rd_idx), .rd_key_o(rd_key), .ready_o(ready), .sbox_use_o(sb_use),
    .sbox_word_o(sb_req), .sbox_word_i(sb_rsp)
  );

  rkey_sbox4 #(.LANES(4)) u_sbox (.word_i(sb_req), .word_o(sb_rsp));

  typedef struct {
    logic [3:0]   idx;
    logic [127:0] exp;
    string        tag;
  } sb_item_t;
  sb_item_t sb_q[$];

  task automatic check(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
    chk_cnt++;
    if (ok) pass_cnt++;
    else $display("FAIL %s: actual %h expected %h", tag, act, exp);
  endtask

  // independent model
  function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] p;
    p = '0;
    for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
    for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h11b << (i - 8));
    return p[7:0];
  endfunction

  function automatic logic [7:0] m_sub(input logic [7:0] x);
    logic [7:0] inv, s, c;
    inv = 8'h00;
    c = 8'h63;
    for (int y = 1; y < 256; y++) if (m_mul(x, 8'(y)) == 8'h01) inv = 8'(y);
    for (int i = 0; i < 8; i++)
      s[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ c[i];
    return s;
  endfunction

  function automatic logic [31:0] m_subw(input logic [31:0] w);
    return {m_sub(w[31:24]), m_sub(w[23:16]), m_sub(w[15:8]), m_sub(w[7:0])};
  endfunction

  function automatic logic [31:0] m_rot(input logic [31:0] w);
    return {w[23:0], w[31:24]};
  endfunction

  logic [31:0] mw [60];

  task automatic build(input logic [255:0] k, input bit is256);
    int nk, nw;
    logic [31:0] t;
    logic [7:0] rc;
    nk = is256 ? 8 : 4;
    nw = is256 ? 60 : 44;
    rc = 8'h01;
    for (int i = 0; i < nk; i++) mw[i] = k[255-32*i -: 32];
    for (int i = nk; i < nw; i++) begin
      t = mw[i-1];
      if (i % nk == 0) begin
        t = m_subw(m_rot(t)) ^ {rc, 24'h0};
        rc = m_mul(rc, 8'h02);
      end else if (nk == 8 && i % 8 == 4) begin
        t = m_subw(t);
      end
      mw[i] = mw[i-nk] ^ t;
    end
  endtask

  function automatic logic [127:0] m_rk(input int r);
    return {mw[4*r], mw[4*r+1], mw[4*r+2], mw[4*r+3]};
  endfunction

  task automatic start(input logic [255:0] k, input bit is256);
    @(negedge clk);
    init = 1'b1;
    key = k;
    len256 = is256;
    @(negedge clk);
    init = 1'b0;
  endtask

  // R6/R7 timing; call right after start; disturb exercises R5
  task automatic measure(input bit is256, input bit disturb, input string tag);
    int n, uses, bad_req;
    logic [31:0] er;
    n = 0; uses = 0; bad_req = 0;
    check(ready == 1'b0, {tag, " R6 ready low after init"}, 128'(ready), 128'(0));
    while (!ready && n < 40) begin
      if (sb_use) begin
        uses++;
        er = mw[4*(n+1)-1];
        if (!is256 || ((n + 1) % 2 == 0)) er = m_rot(er);
        if (sb_req !== er) bad_req++;
      end
      if (is256 && n == 0 && sb_use)
        check(1'b0, {tag, " R7 load cycle uses port"}, 128'(1), 128'(0));
      if (disturb && n == 3) begin
        key = ~key;
        len256 = ~len256;
      end
      @(negedge clk);
      n++;
    end
    check(n == (is256 ? 14 : 10), {tag, " R6 edges to ready"}, 128'(n), 128'(is256 ? 14 : 10));
    check(uses == (is256 ? 13 : 10), {tag, " R7 port cycles"}, 128'(uses), 128'(is256 ? 13 : 10));
    check(bad_req == 0, {tag, " R7 request words"}, 128'(bad_req), 128'(0));
    check(sb_use == 1'b0, {tag, " R7 port idle when ready"}, 128'(sb_use), 128'(0));
  endtask

  task automatic push_all(input bit is256, input string tag);
    for (int r = 0; r < (is256 ? 15 : 11); r++)
      sb_q.push_back('{idx: 4'(r), exp: m_rk(r), tag: $sformatf("%s rk%0d", tag, r)});
    sb_q.push_back('{idx: 4'd15, exp: 128'h0, tag: {tag, " R9 idx15 zero"}});
    wait (sb_q.size() == 0);
    @(negedge clk);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (ready && sb_q.size() > 0) begin
        sb_item_t it;
        it = sb_q.pop_front();
        rd_idx = it.idx;
        #1;
        check(rd_key === it.exp, it.tag, rd_key, it.exp);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", pass_cnt, chk_cnt);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk_cnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  localparam logic [255:0] K128 = {128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h0};
  localparam logic [255:0] K256 =
    256'h603deb1015ca71be2b73aef0857d77811f352c073b6108d72d9810a30914dff4;

  initial begin
    repeat (3) @(negedge clk);
    check(ready == 1'b0 && sb_use == 1'b0, "R1 in reset", {126'h0, ready, sb_use}, 128'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(ready == 1'b0 && sb_use == 1'b0, "R1 after reset", {126'h0, ready, sb_use}, 128'h0);

    // R2 known 128-bit schedule
    build(K128, 1'b0);
    check(m_rk(10) == 128'hd014f9a8c9ee2589e13f0cc8b6630ca6, "R2 model vector",
          m_rk(10), 128'hd014f9a8c9ee2589e13f0cc8b6630ca6);
    start(K128, 1'b0);
    measure(1'b0, 1'b0, "R2 k128");
    push_all(1'b0, "R2 k128");

    // R3/R4 known 256-bit schedule
    build(K256, 1'b1);
    check(m_rk(14) == 128'hfe4890d1e6188d0b046df344706c631e, "R3 model vector",
          m_rk(14), 128'hfe4890d1e6188d0b046df344706c631e);
    start(K256, 1'b1);
    measure(1'b1, 1'b0, "R3 R4 k256");
    push_all(1'b1, "R3 R4 k256");

    // R8 restart mid-run with a different length
    start({128'hffeeddccbbaa99887766554433221100, 128'h0}, 1'b0);
    repeat (4) @(negedge clk);
    build(256'h000102030405060708090a0b0c0d0e0f101112131415161718191a1b1c1d1e1f, 1'b1);
    start(256'h000102030405060708090a0b0c0d0e0f101112131415161718191a1b1c1d1e1f, 1'b1);
    measure(1'b1, 1'b0, "R8 restart");
    push_all(1'b1, "R8 restart");

    // R5 inputs flipped mid-run
    build({128'h00000000000000000000000000000001, 128'h0}, 1'b0);
    start({128'h00000000000000000000000000000001, 128'h0}, 1'b0);
    measure(1'b0, 1'b1, "R5 disturb128");
    push_all(1'b0, "R5 disturb128");

    build(256'hffffffffffffffffffffffffffffffff0000000000000000ffffffffffffffff, 1'b1);
    start(256'hffffffffffffffffffffffffffffffff0000000000000000ffffffffffffffff, 1'b1);
    measure(1'b1, 1'b1, "R5 disturb256");
    push_all(1'b1, "R5 disturb256");

    finish_run();
  end
endmodule